// File: doc/BRIEF.md
# Strobe-Latched 256x4 Static Memory

This block is a small word-organised static memory whose accesses are framed by an active-low strobe rather than by a plain read or write port. The strobe is sampled on the system clock. The sample at which it is first seen low after being high opens an access: the address and a captured select are stored at that sample. Changes on those inputs after that point have no effect until the strobe goes high and falls again.

The cell storage is split into rows and column groups. The high address bits choose a row, and the low bits choose one group of data-width cells within that row. Write data and read data use separate buses. The read path ends in an output latch. That latch follows the addressed word while a read is in progress and keeps it after the strobe rises. The three-state output is modelled as a data value and a drive flag, so several such memories can share one bus behind a simple multiplexer.

A typical host drops the strobe with the address and captured select valid. It then holds the strobe low for at least two more clocks, asserting either write enable with data or output enable for a read. It raises the strobe to close the access.

Top module: `strobe_sram`

## Requirements
- R1: While reset is high, and on the first clock after it, `dq` is zero and `dq_oe` is low.
- R2: `addr` and `sel_cap` are stored on the rising clock edge at which `strobe_n` is sampled low after having been sampled high. Changes on them while the strobe stays low are ignored.
- R3: A write of `din` to the stored address happens on every rising edge after the capture edge at which all of the following hold: `strobe_n` is still low, the stored select is 1, `sel_live` is 1 and `wr_en` is 1. The write touches exactly one column group.
- R4: If the stored select or `sel_live` is 0, no word is written and the output does not drive.
- R5: A read edge is a rising edge after the capture edge with `strobe_n` low, both selects 1, `out_en` 1 and `wr_en` 0. After a read edge, `dq` carries the word at the stored address and `dq_oe` is 1 from the next rising edge onward.
- R6: After a write edge, `dq_oe` is 0 from the next rising edge.
- R7: After `strobe_n` rises, the last read word stays on `dq` with `dq_oe` high for as long as `sel_live` and `out_en` stay 1. One clock after either drops, the drive ends.
- R8: Whenever `dq_oe` is 0, `dq` is 0.
- R9: All 256 words are stored independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Active-low access strobe, sampled on clk |
| addr | input | 8 | Word address, stored at strobe fall |
| sel_cap | input | 1 | Select stored at strobe fall, active high |
| sel_live | input | 1 | Select used as sampled, active high |
| wr_en | input | 1 | Write enable, active high |
| out_en | input | 1 | Output enable, active high |
| din | input | 4 | Write data |
| dq | output | 4 | Output data value, zero when not driving |
| dq_oe | output | 1 | Output drive flag |

## Verification
Every address is written with a pattern that mixes its row and column bits and is then read back. This separates row-decode faults from column-group faults, since an aliased row or group returns a neighbour's code. The bench also runs accesses with the stored select and the live select cleared in turn, and reads the original contents afterwards. In some accesses the address and stored select are flipped one clock after the strobe falls; reading both the intended and the flipped address shows which value was latched. Hold sequences raise the strobe after a read and then drop output enable or the live select, which shows whether the output latch holds its word and releases the bus.

// File: rtl/strobe_sram_pkg.sv
package strobe_sram_pkg;
  // default geometry of the memory
  parameter int DEF_ADDR_W = 8;
  parameter int DEF_DATA_W = 4;
  parameter int DEF_COL_W  = 3;

  // decoded access kind for one clock
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_cap,
  output logic              fall,
  output logic              cyc_open,
  output logic [ADDR_W-1:0] addr_q,
  output logic              selc_q
);
  logic strobe_prev;

  // R2: the first low sample after a high one opens an access
  assign fall = strobe_prev & ~strobe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_prev <= 1'b1;
      cyc_open    <= 1'b0;
      addr_q      <= '0;
      selc_q      <= 1'b0;
    end else begin
      strobe_prev <= strobe_n;
      if (strobe_n) begin
        cyc_open <= 1'b0;
      end else if (fall) begin
        cyc_open <= 1'b1;
      end
      if (fall) begin
        addr_q <= addr;
        selc_q <= sel_cap;
      end
    end
  end
endmodule

// File: rtl/cell_matrix.sv
module cell_matrix #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4,
  localparam int ROWS   = 1 << ROW_W,
  localparam int GROUPS = 1 << COL_W
) (
  input  logic                     clk,
  input  logic [ROW_W-1:0]         row,
  input  logic [GROUPS-1:0]        col_we,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  output logic [GROUPS*DATA_W-1:0] grp_q
);
  // one narrow memory per column group, all sharing the row decode
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [DATA_W-1:0] cells [ROWS];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (col_we[g]) begin
        cells[row] <= wr_data;
      end
      if (rd_en) begin
        rd_q <= cells[row];
      end
    end

    assign grp_q[g*DATA_W +: DATA_W] = rd_q;
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int COL_W  = 3,
  parameter int DATA_W = 4,
  localparam int GROUPS = 1 << COL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_fire,
  input  logic                     strobe_n,
  input  logic                     sel_live,
  input  logic                     out_en,
  input  logic [COL_W-1:0]         col,
  input  logic [GROUPS*DATA_W-1:0] grp_q,
  output logic [DATA_W-1:0]        dq,
  output logic                     dq_oe
);
  logic [COL_W-1:0]  col_q;
  logic              drv;
  logic              drv_nx;
  logic [DATA_W-1:0] word_sel;

  assign word_sel = grp_q[col_q*DATA_W +: DATA_W];

  // R5 R6 R7: the latch follows a read, holds while strobe is high
  always_comb begin
    if (rd_fire) begin
      drv_nx = 1'b1;
    end else if (strobe_n) begin
      drv_nx = drv & sel_live & out_en;
    end else begin
      drv_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      drv   <= 1'b0;
      dq    <= '0;
      dq_oe <= 1'b0;
    end else begin
      if (rd_fire) begin
        col_q <= col;
      end
      drv   <= drv_nx;
      dq_oe <= drv;
      dq    <= drv ? word_sel : '0; // R8
    end
  end
endmodule

// File: rtl/strobe_sram.sv
module strobe_sram
  import strobe_sram_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int COL_W  = DEF_COL_W,
  localparam int ROW_W  = ADDR_W - COL_W,
  localparam int GROUPS = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_cap,
  input  logic              sel_live,
  input  logic              wr_en,
  input  logic              out_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe
);
  logic                     fall;
  logic                     cyc_open;
  logic [ADDR_W-1:0]        addr_q;
  logic                     selc_q;
  acc_kind_t                acc;
  logic                     rd_fire;
  logic                     wr_fire;
  logic [ROW_W-1:0]         row;
  logic [COL_W-1:0]         col;
  logic [GROUPS-1:0]        col_we;
  logic [GROUPS*DATA_W-1:0] grp_q;

  strobe_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .strobe_n(strobe_n),
    .addr    (addr),
    .sel_cap (sel_cap),
    .fall    (fall),
    .cyc_open(cyc_open),
    .addr_q  (addr_q),
    .selc_q  (selc_q)
  );

  // R3 R4 R5: access decode from the stored and live controls
  always_comb begin
    acc = ACC_IDLE;
    if (cyc_open && !strobe_n && selc_q && sel_live) begin
      if (wr_en) begin
        acc = ACC_WRITE;
      end else if (out_en) begin
        acc = ACC_READ;
      end
    end
  end

  assign rd_fire = (acc == ACC_READ);
  assign wr_fire = (acc == ACC_WRITE);
  assign row     = addr_q[ADDR_W-1:COL_W];
  assign col     = addr_q[COL_W-1:0];

  // column decoder gated by the write decision
  for (genvar g = 0; g < GROUPS; g++) begin : g_cdec
    assign col_we[g] = wr_fire && (col == COL_W'(g));
  end

  cell_matrix #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_mat (
    .clk    (clk),
    .row    (row),
    .col_we (col_we),
    .wr_data(din),
    .rd_en  (rd_fire),
    .grp_q  (grp_q)
  );

  out_stage #(.COL_W(COL_W), .DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .rd_fire (rd_fire),
    .strobe_n(strobe_n),
    .sel_live(sel_live),
    .out_en  (out_en),
    .col     (col),
    .grp_q   (grp_q),
    .dq      (dq),
    .dq_oe   (dq_oe)
  );
endmodule

// File: rtl/strobe_sram_chk.sv
module strobe_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int GROUPS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_n,
  input logic              sel_live,
  input logic              cyc_open,
  input logic [ADDR_W-1:0] addr_q,
  input logic              rd_fire,
  input logic              wr_fire,
  input logic [GROUPS-1:0] col_we,
  input logic [DATA_W-1:0] dq,
  input logic              dq_oe
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (cyc_open && !strobe_n) |=> $stable(addr_q)); // R2
  AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(col_we)); // R3
  AST_WR_ONE_GROUP: assert property (@(posedge clk) disable iff (rst) wr_fire |-> ($countones(col_we) == 1)); // R3
  AST_DESEL_DARK: assert property (@(posedge clk) disable iff (rst) !sel_live |=> ##1 !dq_oe); // R4
  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (rst) rd_fire |=> ##1 dq_oe); // R5
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst) wr_fire |=> ##1 !dq_oe); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !dq_oe |-> (dq == '0)); // R8
endmodule

bind strobe_sram strobe_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GROUPS(GROUPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strobe_n(strobe_n),
  .sel_live(sel_live),
  .cyc_open(cyc_open),
  .addr_q  (addr_q),
  .rd_fire (rd_fire),
  .wr_fire (wr_fire),
  .col_we  (col_we),
  .dq      (dq),
  .dq_oe   (dq_oe)
);

// File: tb/sim_strobe_sram.sv
module sim_strobe_sram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_n = 1'b1;
  logic [7:0] addr = '0;
  logic       sel_cap = 1'b0;
  logic       sel_live = 1'b0;
  logic       wr_en = 1'b0;
  logic       out_en = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] dq;
  logic       dq_oe;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  strobe_sram u0 (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .addr(addr), .sel_cap(sel_cap),
    .sel_live(sel_live), .wr_en(wr_en), .out_en(out_en), .din(din),
    .dq(dq), .dq_oe(dq_oe)
  );

  function automatic logic [3:0] pat(input int a);
    return 4'(a) ^ 4'(a >> 4) ^ 4'h6;
  endfunction

  task automatic chk(input string req, input logic [3:0] got_d, input logic [3:0] exp_d,
                     input logic got_o, input logic exp_o);
    total++;
    if (got_d !== exp_d || got_o !== exp_o) begin
      bad++;
      $display("FAIL %s: dq=%h oe=%b expected dq=%h oe=%b", req, got_d, got_o, exp_d, exp_o);
    end
  endtask

  // behavioural reference: a plain array plus a few flags
  logic [3:0] m_mem [256];
  bit         m_prev, m_open, m_sc, m_drv, e_oe;
  logic [7:0] m_a;
  logic [3:0] m_val, e_dq;

  always @(posedge clk) begin
    bit rd, wr;
    if (rst) begin
      m_prev = 1; m_open = 0; m_sc = 0; m_drv = 0; e_oe = 0; e_dq = '0; m_val = '0; m_a = '0;
    end else begin
      rd = m_open && !strobe_n && m_sc && sel_live && !wr_en && out_en;
      wr = m_open && !strobe_n && m_sc && sel_live && wr_en;
      e_oe = m_drv;
      e_dq = m_drv ? m_val : 4'h0;
      if (wr) m_mem[m_a] = din;
      if (rd) begin
        m_val = m_mem[m_a];
        m_drv = 1;
      end else if (strobe_n) begin
        m_drv = m_drv && sel_live && out_en;
      end else begin
        m_drv = 0;
      end
      if (m_prev && !strobe_n) begin
        m_a = addr;
        m_sc = sel_cap;
      end
      if (strobe_n) m_open = 0;
      else if (m_prev) m_open = 1;
      m_prev = strobe_n;
    end
  end

  // cycle compare against the reference
  always @(negedge clk) begin
    if (!rst) chk({cur_req, " cycle"}, dq, e_dq, dq_oe, e_oe);
  end

  // one access; the address and stored select are flipped after the capture edge
  task automatic run_cyc(input int a, input logic we_i, input logic [3:0] d,
                         input logic sc, input logic sl, input logic oe_i, input int low_n);
    @(negedge clk);
    strobe_n = 1'b1; sel_live = sl;
    @(negedge clk);
    strobe_n = 1'b0; addr = 8'(a); sel_cap = sc; wr_en = we_i; din = d; out_en = oe_i;
    @(negedge clk);
    addr = ~8'(a); sel_cap = ~sc;
    repeat (low_n - 1) @(negedge clk);
  endtask

  task automatic hold_strobe_high();
    strobe_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", dq, 4'h0, dq_oe, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", dq, 4'h0, dq_oe, 1'b0);

        // fill the whole array: R3 R6
        cur_req = "R3/R6";
        for (int a = 0; a < 256; a++) run_cyc(a, 1'b1, pat(a), 1'b1, 1'b1, 1'b0, 2);

        // read every word back: R5 R9
        cur_req = "R5/R9";
        for (int a = 0; a < 256; a++) begin
          run_cyc(a, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
          chk("R9 word", dq, pat(a), dq_oe, 1'b1);
        end

        // deselected writes leave contents unchanged: R4
        cur_req = "R4";
        run_cyc(3, 1'b1, ~pat(3), 1'b1, 1'b0, 1'b0, 2);
        chk("R4 live deselect no drive", dq, 4'h0, dq_oe, 1'b0);
        run_cyc(77, 1'b1, ~pat(77), 1'b0, 1'b1, 1'b0, 2);
        run_cyc(3, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
        chk("R4 word 3 kept", dq, pat(3), dq_oe, 1'b1);
        run_cyc(77, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
        chk("R4 word 77 kept", dq, pat(77), dq_oe, 1'b1);
        run_cyc(77, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 3);
        chk("R4 stored deselect no drive", dq, 4'h0, dq_oe, 1'b0);

        // late address change ignored: R2
        cur_req = "R2";
        run_cyc(10, 1'b1, 4'h9, 1'b1, 1'b1, 1'b0, 2);
        run_cyc(10, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
        chk("R2 captured address written", dq, 4'h9, dq_oe, 1'b1);
        run_cyc(245, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
        chk("R2 flipped address untouched", dq, pat(245), dq_oe, 1'b1);

        // hold after strobe rises, release on out_en: R7 R8
        cur_req = "R7";
        run_cyc(200, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
        hold_strobe_high();
        repeat (4) begin
          @(negedge clk);
          chk("R7 held word", dq, pat(200), dq_oe, 1'b1);
        end
        out_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7/R8 released by out_en", dq, 4'h0, dq_oe, 1'b0);

        // release by live select
        run_cyc(201, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 3);
        hold_strobe_high();
        @(negedge clk);
        chk("R7 held word 201", dq, pat(201), dq_oe, 1'b1);
        sel_live = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7/R8 released by sel_live", dq, 4'h0, dq_oe, 1'b0);

        // write cycle keeps output dark: R6
        cur_req = "R6";
        run_cyc(20, 1'b1, 4'h3, 1'b1, 1'b1, 1'b1, 3);
        chk("R6 write no drive", dq, 4'h0, dq_oe, 1'b0);
        hold_strobe_high();
        repeat (3) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule